// File: doc/BRIEF.md
# Peripheral Discovery Register Block

This block lets a host processor learn, one entry at a time, which peripherals sit on the chip. The peripheral list is a read-only table fixed at elaboration by parameters. Each entry carries an identifier, an I/O window base and size, a first interrupt line, a count of interrupt lines, and the length of the peripheral's name. The host talks to the block over a simple 32-bit register bus with registered reads. The block also drives one level-sensitive interrupt that tells the host that entries are waiting to be discovered.

The host starts a discovery pass with a restart command. It then reads the step register again and again. Each read of that register retires the entry under the cursor and moves the cursor to the next entry not yet reported. The field registers then show that entry. When the walk runs out, the step read returns a "finished" code and the interrupt drops.

A write to the name-fetch register raises a one-cycle request to an external copy engine. The request carries a 64-bit target address and the current entry's name length.

The cursor is a two-state machine. In `CUR_NONE` no entry is selected; in `CUR_ON` the cursor points at a valid entry. Its transitions are:
- `RESTART`: a restart command moves any state to `CUR_NONE` and clears every reported flag.
- `ADVANCE`: a step read that finds an unreported entry moves `CUR_NONE` or `CUR_ON` to `CUR_ON`.
- `EXHAUST`: a step read that finds no unreported entry moves `CUR_NONE` or `CUR_ON` to `CUR_NONE`.

Top module: `devenum_ctrl`

## Requirements
- R1: After reset, `irq`, `err_flag`, `host64`, `name_req` and `bus_rvalid` are all 0. The cursor is in `CUR_NONE` with no entry reported.
- R2: Writing 0 to offset 0x00 (restart) clears all reported flags, puts the cursor in `CUR_NONE`, and drives `irq` to 1 from the next cycle when the table has at least one entry.
- R3: A read of offset 0x00 marks the current entry reported if the cursor is valid, then moves to the next unreported entry in table order. When the cursor is none, it moves to the first unreported entry instead. If such an entry exists, the read returns 8.
- R4: If a read of offset 0x00 finds no unreported entry, it returns 0, sets the cursor to none and drives `irq` to 0. Later step reads also return 0.
- R5: Reads of the field offsets return the current entry: 0x08 name length, 0x0C ID, 0x10 I/O base, 0x14 I/O size, 0x18 first IRQ, 0x1C IRQ count. Each returns 0 when the cursor is none. For entry i the table holds ID i+1, base BASE_START+i*STRIDE, size STRIDE, first IRQ IRQ_START+i+floor(i/2), IRQ count (i mod 2)+1, and name length 5+3i.
- R6: A write to offset 0x20 stores the written value as bits 63:32 of the name address and sets `host64`. The `host64` flag stays set until reset.
- R7: A write to offset 0x04 while the cursor is valid makes `name_req` a one-cycle pulse in the following cycle. The pulse comes with `name_addr` = {stored upper half, written value} and `name_len` = the current entry's name length. When the cursor is none, the write leaves `name_req` low.
- R8: Each of the following sets the sticky `err_flag` and changes no other state: writing a nonzero value to 0x00, writing any offset other than 0x00, 0x04 or 0x20, or reading any offset other than 0x00 and 0x08 to 0x1C.
- R9: Every read completes exactly one cycle after it is presented, with `bus_rvalid` high for that one cycle. An erroring read returns 0.
- R10: A restart issued in the middle of a walk makes the next step read land on entry 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read completion pulse |
| irq | output | 1 | Level interrupt: entries are waiting |
| err_flag | output | 1 | Sticky protocol error |
| host64 | output | 1 | Sticky: upper name address was written |
| name_req | output | 1 | One-cycle name copy request |
| name_addr | output | 64 | Target address of the name copy |
| name_len | output | 32 | Byte length of the name copy |

## Verification
The assertions assume that the bus carries at most one access per cycle. This means a restart and a step read never land in the same cycle, and `bus_we` is only meaningful while `bus_sel` is high. The bench drives every access as a single-cycle strobe from a task, so these assumptions always hold. It covers both legal accesses and deliberately illegal offsets and op values.

// File: rtl/devenum_pkg.sv
package devenum_pkg;

    typedef struct packed {
        logic [31:0] dev_id;
        logic [31:0] io_base;
        logic [31:0] io_size;
        logic [31:0] irq_first;
        logic [31:0] irq_num;
        logic [31:0] name_bytes;
    } dev_entry_t;

    typedef enum logic {
        CUR_NONE = 1'b0,
        CUR_ON   = 1'b1
    } cur_state_e;

    localparam logic [31:0] STEP_FOUND = 32'h8;
    localparam logic [31:0] STEP_DONE  = 32'h0;

    localparam int unsigned OFF_STEP  = 'h00;
    localparam int unsigned OFF_NAME  = 'h04;
    localparam int unsigned OFF_NLEN  = 'h08;
    localparam int unsigned OFF_ID    = 'h0C;
    localparam int unsigned OFF_BASE  = 'h10;
    localparam int unsigned OFF_SIZE  = 'h14;
    localparam int unsigned OFF_IRQ   = 'h18;
    localparam int unsigned OFF_IRQN  = 'h1C;
    localparam int unsigned OFF_UPPER = 'h20;

    function automatic dev_entry_t make_entry(int unsigned idx,
                                              logic [31:0] base0,
                                              logic [31:0] stride,
                                              logic [31:0] irq0);
        dev_entry_t e;
        e.dev_id     = 32'(idx + 1);
        e.io_base    = base0 + 32'(idx) * stride;
        e.io_size    = stride;
        e.irq_first  = irq0 + 32'(idx + idx / 2);
        e.irq_num    = 32'((idx % 2) + 1);
        e.name_bytes = 32'(5 + 3 * idx);
        return e;
    endfunction

endpackage

// File: rtl/devenum_table.sv
module devenum_table
    import devenum_pkg::*;
#(
    parameter int unsigned NUM_DEV    = 4,
    parameter logic [31:0] BASE_START = 32'h1000_2000,
    parameter logic [31:0] STRIDE     = 32'h0000_1000,
    parameter logic [31:0] IRQ_START  = 32'd3,
    localparam int unsigned IDX_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic [IDX_W-1:0] idx,
    output dev_entry_t       entry
);

    dev_entry_t rom [NUM_DEV];

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_rom
        assign rom[g] = make_entry(g, BASE_START, STRIDE, IRQ_START);
    end

    always_comb begin
        entry = '0;
        for (int k = 0; k < NUM_DEV; k++) begin
            if (int'(idx) == k) entry = rom[k];
        end
    end

endmodule

// File: rtl/devenum_walker.sv
module devenum_walker
    import devenum_pkg::*;
#(
    parameter int unsigned NUM_DEV = 4,
    localparam int unsigned IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_cmd,
    input  logic             step,
    output logic             cur_valid,
    output logic [IDX_W-1:0] cur_idx,
    output logic             step_found,
    output logic             irq
);

    cur_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [NUM_DEV-1:0] rep_q, rep_d, rep_mark;
    logic             irq_q, irq_d;
    logic             found;
    logic [IDX_W-1:0] nxt;
    int               start;

    // Retire the current entry, then find the first unreported one at or after start.
    always_comb begin
        rep_mark = rep_q;
        start    = 0;
        if (state_q == CUR_ON) begin
            rep_mark[idx_q] = 1'b1;
            start           = int'(idx_q) + 1;
        end
        found = 1'b0;
        nxt   = '0;
        for (int j = NUM_DEV - 1; j >= 0; j--) begin
            if (j >= start && !rep_mark[j]) begin
                found = 1'b1;
                nxt   = IDX_W'(j);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        rep_d   = rep_q;
        irq_d   = irq_q;
        if (init_cmd) begin
            state_d = CUR_NONE;          // RESTART
            rep_d   = '0;
            irq_d   = (NUM_DEV > 0);
        end else if (step) begin
            rep_d = rep_mark;
            unique case (found)
                1'b1: begin
                    state_d = CUR_ON;    // ADVANCE
                    idx_d   = nxt;
                end
                1'b0: begin
                    state_d = CUR_NONE;  // EXHAUST
                    irq_d   = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CUR_NONE;
            idx_q   <= '0;
            rep_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            rep_q   <= rep_d;
            irq_q   <= irq_d;
        end
    end

    assign cur_valid  = (state_q == CUR_ON);
    assign cur_idx    = idx_q;
    assign step_found = found;
    assign irq        = irq_q;

    a_r4_irq_falls_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_q) |-> $past(step));
    a_r2_irq_rises_on_init: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(init_cmd));
    a_r3_idx_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        cur_valid |-> (int'(idx_q) < NUM_DEV));
    a_r3_retired_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cur_valid) |=> rep_q[$past(idx_q)]);
    a_r1_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && init_cmd));

endmodule

// File: rtl/devenum_regs.sv
module devenum_regs
    import devenum_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  dev_entry_t        entry,
    input  logic              cur_valid,
    input  logic              step_found,
    output logic              init_cmd,
    output logic              step,
    output logic [31:0]       rdata,
    output logic              rvalid,
    output logic              err_flag,
    output logic              host64,
    output logic              name_req,
    output logic [63:0]       name_addr,
    output logic [31:0]       name_len
);

    logic        rd, wr, bad, name_wr, upper_wr;
    logic [31:0] mux;
    logic [31:0] upper_q;
    int unsigned off;

    assign off = int'(bus_addr);
    assign rd  = bus_sel && !bus_we;
    assign wr  = bus_sel && bus_we;

    always_comb begin
        init_cmd = 1'b0;
        step     = 1'b0;
        name_wr  = 1'b0;
        upper_wr = 1'b0;
        bad      = 1'b0;
        mux      = '0;
        if (wr) begin
            unique case (off)
                OFF_STEP:  if (bus_wdata == 32'h0) init_cmd = 1'b1; else bad = 1'b1;
                OFF_NAME:  name_wr  = 1'b1;
                OFF_UPPER: upper_wr = 1'b1;
                default:   bad      = 1'b1;
            endcase
        end else if (rd) begin
            unique case (off)
                OFF_STEP: begin
                    step = 1'b1;
                    mux  = step_found ? STEP_FOUND : STEP_DONE;
                end
                OFF_NLEN: mux = cur_valid ? entry.name_bytes : '0;
                OFF_ID:   mux = cur_valid ? entry.dev_id     : '0;
                OFF_BASE: mux = cur_valid ? entry.io_base    : '0;
                OFF_SIZE: mux = cur_valid ? entry.io_size    : '0;
                OFF_IRQ:  mux = cur_valid ? entry.irq_first  : '0;
                OFF_IRQN: mux = cur_valid ? entry.irq_num    : '0;
                default:  bad = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata     <= '0;
            rvalid    <= 1'b0;
            err_flag  <= 1'b0;
            host64    <= 1'b0;
            upper_q   <= '0;
            name_req  <= 1'b0;
            name_addr <= '0;
            name_len  <= '0;
        end else begin
            rvalid   <= rd;
            rdata    <= mux;
            name_req <= name_wr && cur_valid;
            if (bad) err_flag <= 1'b1;
            if (upper_wr) begin
                upper_q <= bus_wdata;
                host64  <= 1'b1;
            end
            if (name_wr && cur_valid) begin
                name_addr <= {upper_q, bus_wdata};
                name_len  <= entry.name_bytes;
            end
        end
    end

    a_r9_read_completes: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);
    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd));
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
    a_r6_host64_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        host64 |=> host64);
    a_r7_req_needs_cursor: assert property (@(posedge clk) disable iff (!rst_n)
        name_req |-> $past(cur_valid && wr));

endmodule

// File: rtl/devenum_ctrl.sv
module devenum_ctrl
    import devenum_pkg::*;
#(
    parameter int unsigned NUM_DEV    = 4,
    parameter int unsigned ADDR_W     = 6,
    parameter logic [31:0] BASE_START = 32'h1000_2000,
    parameter logic [31:0] STRIDE     = 32'h0000_1000,
    parameter logic [31:0] IRQ_START  = 32'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              irq,
    output logic              err_flag,
    output logic              host64,
    output logic              name_req,
    output logic [63:0]       name_addr,
    output logic [31:0]       name_len
);

    localparam int unsigned IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic             init_cmd, step, cur_valid, step_found;
    logic [IDX_W-1:0] cur_idx;
    dev_entry_t       entry;

    devenum_table #(
        .NUM_DEV(NUM_DEV), .BASE_START(BASE_START),
        .STRIDE(STRIDE), .IRQ_START(IRQ_START)
    ) u_table (
        .idx(cur_idx), .entry(entry)
    );

    devenum_walker #(.NUM_DEV(NUM_DEV)) u_walker (
        .clk(clk), .rst_n(rst_n), .init_cmd(init_cmd), .step(step),
        .cur_valid(cur_valid), .cur_idx(cur_idx),
        .step_found(step_found), .irq(irq)
    );

    devenum_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .entry(entry),
        .cur_valid(cur_valid), .step_found(step_found),
        .init_cmd(init_cmd), .step(step), .rdata(bus_rdata),
        .rvalid(bus_rvalid), .err_flag(err_flag), .host64(host64),
        .name_req(name_req), .name_addr(name_addr), .name_len(name_len)
    );

endmodule

// File: tb/devenum_ctrl_test.sv
module devenum_ctrl_test;

    localparam int NDEV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, irq, err_flag, host64, name_req;
    logic [63:0] name_addr;
    logic [31:0] name_len;

    int n_chk = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        done = 1'b0;

    always #4 clk = ~clk;

    devenum_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq(irq), .err_flag(err_flag),
        .host64(host64), .name_req(name_req), .name_addr(name_addr),
        .name_len(name_len)
    );

    function automatic logic [31:0] f_id(int i);   return 32'(i + 1); endfunction
    function automatic logic [31:0] f_base(int i); return 32'h1000_2000 + 32'(i) * 32'h1000; endfunction
    function automatic logic [31:0] f_irq(int i);  return 32'(3 + i + i / 2); endfunction
    function automatic logic [31:0] f_cnt(int i);  return 32'((i % 2) + 1); endfunction
    function automatic logic [31:0] f_len(int i);  return 32'(5 + 3 * i); endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic fields(int i, string req);
        rd(6'h08, f_len(i), req);
        rd(6'h0C, f_id(i), req);
        rd(6'h10, f_base(i), req);
        rd(6'h14, 32'h1000, req);
        rd(6'h18, f_irq(i), req);
        rd(6'h1C, f_cnt(i), req);
    endtask

    // Monitor: pops expected read data as completions arrive
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R9: unexpected completion actual %h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), {32'h0, bus_rdata}, {32'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq", irq, 0);
        check("R1 err", err_flag, 0);
        check("R1 host64", host64, 0);
        check("R1 name_req", name_req, 0);
        check("R1 rvalid", bus_rvalid, 0);
        rd(6'h0C, 0, "R5 none id");
        @(negedge clk);
        check("R9 single pulse", bus_rvalid, 0);

        wr(6'h00, 0);
        check("R2 irq after restart", irq, 1);
        wr(6'h20, 32'hABCD_0001);
        check("R6 host64", host64, 1);

        for (int i = 0; i < NDEV; i++) begin
            rd(6'h00, 32'h8, "R3 step found");
            fields(i, "R5 fields");
            if (i == 1) begin
                wr(6'h04, 32'h0000_5000);
                check("R7 pulse", name_req, 1);
                check("R7 addr", name_addr, 64'hABCD_0001_0000_5000);
                check("R7 len", name_len, 32'd8);
                @(negedge clk);
                check("R7 pulse ends", name_req, 0);
            end
            if (i == 2) begin
                wr(6'h00, 32'h3);
                check("R8 err op", err_flag, 1);
                check("R8 irq kept", irq, 1);
                rd(6'h0C, f_id(2), "R8 cursor kept");
                rd(6'h24, 0, "R8 bad read data");
                wr(6'h10, 32'h55);
                rd(6'h10, f_base(2), "R8 bad write ignored");
                check("R8 err sticky", err_flag, 1);
            end
        end

        rd(6'h00, 32'h0, "R4 done");
        check("R4 irq low", irq, 0);
        rd(6'h00, 32'h0, "R4 done again");
        rd(6'h0C, 0, "R5 none after walk");
        wr(6'h04, 32'h1234);
        check("R7 ignored without cursor", name_req, 0);
        check("R6 host64 sticky", host64, 1);

        wr(6'h00, 0);
        check("R2 irq re-raised", irq, 1);
        rd(6'h00, 32'h8, "R10 first");
        rd(6'h00, 32'h8, "R10 second");
        rd(6'h0C, f_id(1), "R10 at entry1");
        wr(6'h00, 0);
        rd(6'h0C, 0, "R2 cursor none");
        rd(6'h00, 32'h8, "R10 restart step");
        rd(6'h0C, f_id(0), "R10 back at entry0");
        rd(6'h10, f_base(0), "R10 entry0 base");

        repeat (3) @(negedge clk);
        check("R9 all reads completed", exp_q.size(), 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule